// File: doc/BRIEF.md
# Unaligned Access Fragment Splitter

This block sits between a processor's load/store path and a byte-addressed target that can only handle transfers confined to a single aligned longword. It accepts one word or longword access whose first byte lies at an arbitrary address. It breaks the access into one or two fragment requests. Each fragment carries an address, an exact byte count of 1 to 3 and right-aligned data. The target therefore never has to perform a whole-longword read-modify-write, and it never sees more bytes than the access touches.

The caller supplies two addresses. The first is the address of the first byte. The second is an address inside the following longword. The two may be unrelated when the access crosses a page boundary, so the high fragment is addressed only through the second address, with its two low bits cleared. Read data comes back from the target right-aligned per fragment, and the block reassembles it into a single right-aligned result. A request that is not an unaligned word or longword is refused without any downstream traffic.

The controller has five states. `ST_IDLE` waits for a request, and accepting one takes it to `ST_LOW`, or to `ST_REJECT` if the request is illegal. `ST_LOW` presents the first fragment. On its handshake the controller moves to `ST_HIGH` when a second fragment is needed, and to `ST_FINISH` otherwise. `ST_HIGH` presents the second fragment and moves to `ST_FINISH` on its handshake. `ST_FINISH` and `ST_REJECT` each last one cycle and then return to `ST_IDLE`.

Top module: `unaligned_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `frag_valid`, `done` and `illegal` are 0.
- R2: A longword request with byte offset k = `req_addr[1:0]` in 1..3 produces a first fragment at `req_addr` with count 4−k. It then produces a second fragment with count k at `req_next_addr` with bits [1:0] forced to 0.
- R3: For a longword read, `rdata` equals the first fragment's data ORed with the second fragment's data shifted left by 8×(4−k).
- R4: A word request at offset 1 produces exactly one fragment, at `req_addr` with count 2. `rdata` equals that fragment's data.
- R5: A word request at offset 3 produces a 1-byte fragment at `req_addr`, then a 1-byte fragment at `req_next_addr` with bits [1:0] forced to 0. `rdata` equals the low byte ORed with the high byte shifted left by 8.
- R6: For writes, the first fragment's `frag_wdata` is `req_wdata` masked to its count. The second fragment's data is `req_wdata` shifted right by 8×(first count) and masked to its own count. The mask for n bytes is 2^(8n)−1. As a result, a byte-granular target changes exactly the addressed bytes.
- R7: The first fragment is always issued before the second, and no other fragments are issued. `done` rises in the cycle after the handshake of the last fragment.
- R8: `req_ready` is 0 from acceptance through the `done` cycle and returns to 1 in the next cycle. `done` is a single-cycle pulse.
- R9: `req_size` encodes 0 = byte, 1 = word, 2 = longword and 3 = reserved. A byte request, a reserved size, a longword at offset 0, or a word at offset 0 or 2 raises `illegal` for one cycle in the cycle after acceptance. Such a request produces no fragment and no `done`.
- R10: While `frag_valid` is 1 and `frag_ready` is 0, `frag_valid`, `frag_addr`, `frag_cnt`, `frag_write` and `frag_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address of the first byte |
| req_next_addr | input | ADDR_W | Any address inside the following longword |
| req_wdata | input | 32 | Right-aligned write data |
| frag_valid | output | 1 | Fragment request present |
| frag_ready | input | 1 | Target accepts the fragment; read data is valid in the same cycle |
| frag_write | output | 1 | Fragment direction |
| frag_addr | output | ADDR_W | Fragment byte address |
| frag_cnt | output | 2 | Fragment byte count, 1 to 3 |
| frag_wdata | output | 32 | Right-aligned, masked fragment write data |
| frag_rdata | input | 32 | Right-aligned fragment read data |
| done | output | 1 | One-cycle pulse at the end of a legal access |
| rdata | output | 32 | Reassembled read result, valid with `done` on reads |
| illegal | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situation to produce from the ports is a fragment held pending across several cycles while the second-longword address disagrees with the first address plus four. Only this combination shows whether the high fragment really follows the separate address with its low bits cleared, and whether every fragment field stays frozen under back-pressure. The bench gives its target model a programmable acceptance delay. It then issues crossing accesses whose second address lies in a distant longword and has nonzero low bits. It checks the logged fragment sequence, the handshake-to-`done` cycle, and the byte contents of both target longwords after writes.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

    localparam int WORD_BITS = 32;
    localparam int CNT_W     = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FINISH,
        ST_REJECT
    } state_e;

    function automatic logic [WORD_BITS-1:0] len_mask(input logic [CNT_W-1:0] n);
        logic [WORD_BITS-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_BITS / 8; i++) begin
            if (i < int'(n)) m[i*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/splitter_plan.sv
module splitter_plan
    import splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]           size,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [ADDR_W-1:0]    next_addr,
    input  logic [WORD_BITS-1:0] wdata,
    output logic                 legal,
    output logic                 two_frags,
    output logic [CNT_W-1:0]     lo_cnt,
    output logic [CNT_W-1:0]     hi_cnt,
    output logic [ADDR_W-1:0]    hi_addr,
    output logic [WORD_BITS-1:0] lo_wdata,
    output logic [WORD_BITS-1:0] hi_wdata
);

    localparam logic [ADDR_W-1:0] LW_ALIGN = ~(ADDR_W'(3));

    logic [1:0] offs;
    logic       is_word;
    logic       is_long;

    assign offs    = addr[1:0];
    assign is_word = (size == SZ_WORD);
    assign is_long = (size == SZ_LONG);

    always_comb begin
        legal     = (is_long && offs != 2'd0) || (is_word && offs[0]);
        two_frags = is_long || (is_word && offs == 2'd3);
        if (is_long) begin
            lo_cnt = 2'(3'd4 - {1'b0, offs});
            hi_cnt = offs;
        end else begin
            lo_cnt = (offs == 2'd1) ? 2'd2 : 2'd1;
            hi_cnt = 2'd1;
        end
    end

    assign hi_addr  = next_addr & LW_ALIGN;
    assign lo_wdata = wdata & len_mask(lo_cnt);
    assign hi_wdata = (wdata >> {lo_cnt, 3'b000}) & len_mask(hi_cnt);

endmodule

// File: rtl/splitter_merge.sv
module splitter_merge
    import splitter_pkg::*;
(
    input  logic [WORD_BITS-1:0] lo_data,
    input  logic [WORD_BITS-1:0] hi_data,
    input  logic [CNT_W-1:0]     lo_cnt,
    input  logic                 two_frags,
    output logic [WORD_BITS-1:0] result
);

    always_comb begin
        result = lo_data;
        if (two_frags) result = lo_data | (hi_data << {lo_cnt, 3'b000});
    end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
    import splitter_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ADDR_W-1:0]    req_next_addr,
    input  logic [31:0]          req_wdata,
    output logic                 frag_valid,
    input  logic                 frag_ready,
    output logic                 frag_write,
    output logic [ADDR_W-1:0]    frag_addr,
    output logic [1:0]           frag_cnt,
    output logic [31:0]          frag_wdata,
    input  logic [31:0]          frag_rdata,
    output logic                 done,
    output logic [31:0]          rdata,
    output logic                 illegal
);

    state_e state_q, state_d;

    logic                 p_legal, p_two;
    logic [CNT_W-1:0]     p_lo_cnt, p_hi_cnt;
    logic [ADDR_W-1:0]    p_hi_addr;
    logic [WORD_BITS-1:0] p_lo_wd, p_hi_wd;

    logic                 two_q, write_q;
    logic [CNT_W-1:0]     lo_cnt_q, hi_cnt_q;
    logic [ADDR_W-1:0]    lo_addr_q, hi_addr_q;
    logic [WORD_BITS-1:0] lo_wd_q, hi_wd_q;
    logic [WORD_BITS-1:0] lo_rd_q, hi_rd_q;
    logic [WORD_BITS-1:0] merged;
    logic                 accept;

    splitter_plan #(.ADDR_W(ADDR_W)) u_plan (
        .size      (req_size),
        .addr      (req_addr),
        .next_addr (req_next_addr),
        .wdata     (req_wdata),
        .legal     (p_legal),
        .two_frags (p_two),
        .lo_cnt    (p_lo_cnt),
        .hi_cnt    (p_hi_cnt),
        .hi_addr   (p_hi_addr),
        .lo_wdata  (p_lo_wd),
        .hi_wdata  (p_hi_wd)
    );

    splitter_merge u_merge (
        .lo_data   (lo_rd_q),
        .hi_data   (hi_rd_q),
        .lo_cnt    (lo_cnt_q),
        .two_frags (two_q),
        .result    (merged)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = p_legal ? ST_LOW : ST_REJECT;
            ST_LOW:    if (frag_ready) state_d = two_q ? ST_HIGH : ST_FINISH;
            ST_HIGH:   if (frag_ready) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and returned-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            two_q     <= 1'b0;
            write_q   <= 1'b0;
            lo_cnt_q  <= '0;
            hi_cnt_q  <= '0;
            lo_addr_q <= '0;
            hi_addr_q <= '0;
            lo_wd_q   <= '0;
            hi_wd_q   <= '0;
            lo_rd_q   <= '0;
            hi_rd_q   <= '0;
        end else begin
            if (accept) begin
                two_q     <= p_two;
                write_q   <= req_write;
                lo_cnt_q  <= p_lo_cnt;
                hi_cnt_q  <= p_hi_cnt;
                lo_addr_q <= req_addr;
                hi_addr_q <= p_hi_addr;
                lo_wd_q   <= p_lo_wd;
                hi_wd_q   <= p_hi_wd;
                lo_rd_q   <= '0;
                hi_rd_q   <= '0;
            end
            if (state_q == ST_LOW && frag_ready && !write_q)  lo_rd_q <= frag_rdata;
            if (state_q == ST_HIGH && frag_ready && !write_q) hi_rd_q <= frag_rdata;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        frag_valid = 1'b0;
        frag_write = write_q;
        frag_addr  = lo_addr_q;
        frag_cnt   = lo_cnt_q;
        frag_wdata = write_q ? lo_wd_q : '0;
        done       = 1'b0;
        illegal    = 1'b0;
        rdata      = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOW:    frag_valid = 1'b1;
            ST_HIGH: begin
                frag_valid = 1'b1;
                frag_addr  = hi_addr_q;
                frag_cnt   = hi_cnt_q;
                frag_wdata = write_q ? hi_wd_q : '0;
            end
            ST_FINISH: begin
                done  = 1'b1;
                rdata = write_q ? '0 : merged;
            end
            ST_REJECT: illegal = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    // checks
    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst_n) |=> (req_ready && !frag_valid && !done && !illegal));

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (frag_cnt != 2'd0));

    assert_high_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && state_q == ST_HIGH) |-> (frag_addr[1:0] == 2'b00));

    assert_wdata_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_write) |-> ((frag_wdata & ~len_mask(frag_cnt)) == '0));

    assert_low_then_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOW && frag_ready && two_q) |=> (frag_valid && state_q == ST_HIGH));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && frag_ready) |=> done);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid || done) |-> !req_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!frag_valid && !done) ##1 (!frag_valid && req_ready));

    assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready) |=> (frag_valid && $stable(frag_addr) &&
            $stable(frag_cnt) && $stable(frag_wdata) && $stable(frag_write)));

endmodule

// File: tb/sim_unaligned_splitter.sv
`timescale 1ns/1ps
module sim_unaligned_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = 2'd0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_next_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        frag_valid;
    logic        frag_ready = 1'b0;
    logic        frag_write;
    logic [31:0] frag_addr;
    logic [1:0]  frag_cnt;
    logic [31:0] frag_wdata;
    logic [31:0] frag_rdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic        illegal;

    always #2.5 clk = ~clk;

    unaligned_splitter #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_size(req_size),
        .req_write(req_write), .req_addr(req_addr), .req_next_addr(req_next_addr),
        .req_wdata(req_wdata),
        .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_write(frag_write),
        .frag_addr(frag_addr), .frag_cnt(frag_cnt), .frag_wdata(frag_wdata),
        .frag_rdata(frag_rdata),
        .done(done), .rdata(rdata), .illegal(illegal)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // byte-addressed target model
    logic [31:0] mem [16];
    logic [31:0] lg_addr [4];
    logic [1:0]  lg_cnt  [4];
    logic [31:0] lg_wd   [4];
    int          lg_n = 0;
    int          hs_cyc = 0;
    int          delay = 0;

    function automatic logic [31:0] bmask(input int n);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (i < n) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [7:0] byte_of(input logic [31:0] a);
        logic [31:0] w = mem[a[5:2]];
        return w[a[1:0]*8 +: 8];
    endfunction

    initial begin : target
        int wt = 0;
        forever begin
            @(negedge clk);
            if (frag_ready) begin
                frag_ready = 1'b0;
                wt = 0;
            end else if (frag_valid) begin
                if (wt >= delay) begin
                    logic [3:0] ix;
                    int sh;
                    frag_ready = 1'b1;
                    if (lg_n < 4) begin
                        lg_addr[lg_n] = frag_addr;
                        lg_cnt[lg_n]  = frag_cnt;
                        lg_wd[lg_n]   = frag_wdata;
                    end
                    lg_n++;
                    hs_cyc = cyc + 1;
                    ix = frag_addr[5:2];
                    sh = 8 * int'(frag_addr[1:0]);
                    if (frag_write)
                        mem[ix] = (mem[ix] & ~(bmask(int'(frag_cnt)) << sh)) |
                                  ((frag_wdata & bmask(int'(frag_cnt))) << sh);
                    else
                        frag_rdata = (mem[ix] >> sh) & bmask(int'(frag_cnt));
                end else begin
                    wt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 16; i++)
            mem[i] = {8'hA0 + 8'(i), 8'hB0 + 8'(i), 8'hC0 + 8'(i), 8'hD0 + 8'(i)};
    endtask

    // issue one request, wait for completion
    task automatic issue(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] n,
                         input bit wr, input logic [31:0] wd, input int dly,
                         output bit got_done, output bit got_ill, output int wait_it,
                         output int done_at, output logic [31:0] rd, output bit busy_ok);
        got_done = 0; got_ill = 0; wait_it = 0; done_at = -1; rd = '0; busy_ok = 1;
        lg_n = 0; delay = dly;
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = a; req_next_addr = n;
        req_write = wr; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (done || illegal) begin
                got_done = done; got_ill = illegal; done_at = cyc; rd = rdata;
                if (req_ready) busy_ok = 0;
                break;
            end
            if (req_ready) busy_ok = 0;
            wait_it++;
        end
        if (!got_done && !got_ill) chk(0, "watchdog: no completion", 32'h0, 32'h1);
    endtask

    // legal access: derive fragments from the byte span and check everything
    task automatic legal_case(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] n,
                              input bit wr, input logic [31:0] wd, input int dly, input string tag);
        bit gd, gi, bz;
        int wi, da;
        logic [31:0] rd, exp_rd;
        logic [31:0] exp_mem [16];
        int nb, lo_n, hi_n;
        logic [31:0] n_al;
        nb   = (sz == 2'd2) ? 4 : 2;
        lo_n = (4 - int'(a[1:0]) < nb) ? 4 - int'(a[1:0]) : nb;
        hi_n = nb - lo_n;
        n_al = {n[31:2], 2'b00};
        exp_rd = '0;
        for (int i = 0; i < 16; i++) exp_mem[i] = mem[i];
        for (int k = 0; k < nb; k++) begin
            logic [31:0] ba = (k < lo_n) ? a + 32'(k) : n_al + 32'(k - lo_n);
            exp_rd[k*8 +: 8] = byte_of(ba);
            exp_mem[ba[5:2]][ba[1:0]*8 +: 8] = wd[k*8 +: 8];
        end
        issue(sz, a, n, wr, wd, dly, gd, gi, wi, da, rd, bz);
        chk(gd && !gi, {tag, " R7 done"}, {31'b0, gd}, 32'h1);
        chk(da == hs_cyc, {tag, " R7 done cycle"}, 32'(da), 32'(hs_cyc));
        chk(lg_n == (hi_n > 0 ? 2 : 1), {tag, " R7 fragment count"}, 32'(lg_n), 32'(hi_n > 0 ? 2 : 1));
        chk(lg_addr[0] == a && lg_cnt[0] == 2'(lo_n), {tag, " R2 low fragment"},
            {lg_addr[0][29:0], lg_cnt[0]}, {a[29:0], 2'(lo_n)});
        if (hi_n > 0)
            chk(lg_addr[1] == n_al && lg_cnt[1] == 2'(hi_n), {tag, " R2 high fragment"},
                {lg_addr[1][29:0], lg_cnt[1]}, {n_al[29:0], 2'(hi_n)});
        if (wr) begin
            chk(lg_wd[0] == (wd & bmask(lo_n)), {tag, " R6 low wdata"}, lg_wd[0], wd & bmask(lo_n));
            if (hi_n > 0)
                chk(lg_wd[1] == ((wd >> (8*lo_n)) & bmask(hi_n)), {tag, " R6 high wdata"},
                    lg_wd[1], (wd >> (8*lo_n)) & bmask(hi_n));
            chk(mem[a[5:2]] == exp_mem[a[5:2]], {tag, " R6 low longword"}, mem[a[5:2]], exp_mem[a[5:2]]);
            chk(mem[n_al[5:2]] == exp_mem[n_al[5:2]], {tag, " R6 high longword"},
                mem[n_al[5:2]], exp_mem[n_al[5:2]]);
        end else begin
            chk(rd == exp_rd, {tag, " R3 R5 read result"}, rd, exp_rd);
        end
        chk(bz, {tag, " R8 ready low while busy"}, {31'b0, bz}, 32'h1);
        @(negedge clk);
        chk(req_ready && !done, {tag, " R8 ready after done"}, {30'b0, req_ready, done}, 32'h2);
    endtask

    task automatic illegal_case(input logic [1:0] sz, input logic [31:0] a, input string tag);
        bit gd, gi, bz;
        int wi, da;
        logic [31:0] rd;
        issue(sz, a, a + 32'd4, 1'b1, 32'hDEADBEEF, 0, gd, gi, wi, da, rd, bz);
        chk(gi && !gd && wi == 0, {tag, " R9 illegal pulse"}, {30'b0, gi, gd}, 32'h2);
        repeat (3) @(negedge clk);
        chk(lg_n == 0 && req_ready && !illegal, {tag, " R9 no fragments"}, 32'(lg_n), 32'h0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready && !frag_valid && !done && !illegal, "R1 reset state",
            {28'b0, req_ready, frag_valid, done, illegal}, 32'h8);
    endtask

    task automatic t_long_reads();
        preload();
        legal_case(2'd2, 32'h0000_0005, 32'h0000_0032, 1'b0, 32'h0, 0, "long rd off1 R2 R3");
        legal_case(2'd2, 32'h0000_000A, 32'h0000_0023, 1'b0, 32'h0, 2, "long rd off2 R2 R3 R10");
        legal_case(2'd2, 32'h0000_001F, 32'h0000_0039, 1'b0, 32'h0, 1, "long rd off3 R2 R3");
    endtask

    task automatic t_word_reads();
        preload();
        legal_case(2'd1, 32'h0000_0011, 32'h0000_0017, 1'b0, 32'h0, 0, "word rd off1 R4");
        legal_case(2'd1, 32'h0000_0027, 32'h0000_0006, 1'b0, 32'h0, 3, "word rd off3 R5");
    endtask

    task automatic t_writes();
        preload();
        legal_case(2'd2, 32'h0000_0033, 32'h0000_000D, 1'b1, 32'h1234_5678, 2, "long wr off3 R6 R10");
        legal_case(2'd2, 32'h0000_0009, 32'h0000_002E, 1'b1, 32'hCAFE_F00D, 0, "long wr off1 R6");
        legal_case(2'd1, 32'h0000_0015, 32'h0000_0019, 1'b1, 32'hFFFF_ABCD, 1, "word wr off1 R4 R6");
        legal_case(2'd1, 32'h0000_003B, 32'h0000_0000, 1'b1, 32'h0000_9A5C, 0, "word wr off3 R5 R6");
    endtask

    task automatic t_illegal();
        illegal_case(2'd0, 32'h0000_0013, "byte size");
        illegal_case(2'd2, 32'h0000_0010, "long off0");
        illegal_case(2'd1, 32'h0000_0012, "word off2");
        illegal_case(2'd1, 32'h0000_0014, "word off0");
        illegal_case(2'd3, 32'h0000_0011, "reserved size");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        preload();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_long_reads();
        t_word_reads();
        t_writes();
        t_illegal();
        legal_case(2'd2, 32'h0000_0002, 32'h0000_0007, 1'b0, 32'h0, 0, "back-to-back R7 R8");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule